// File: doc/BRIEF.md
# Modulator Clock and Sync Interface Controller

This block lives on the decimator side of a one-bit delta-sigma link. It makes the modulator master clock by dividing the system clock. It turns an external synchronisation edge into a modulator sync pulse that is placed on the master clock grid. It picks one bit out of every four master clock periods from the returning bit stream. It also keeps a sticky over-range error that is handed to the status of the next output word.

Both generated signals stay quiet until their configuration enables are set. With `HALF_DIV` = 8 and a 32.768 MHz system clock, the master clock runs at the nominal 2.048 MHz with a 50% duty cycle. The sync pulse starts on a master clock rising edge and lasts two master clock periods. Because it spans a whole falling edge, the modulator latches it there. The timing instant t0 is the master clock rising edge that follows that falling edge. Bit phase is counted from t0, and the data bit is taken at phase 2 of each four-period bit slot.

Top module: `mcs_ctrl`

## Requirements
- R1: While `cfg_mclk_en` is low, including after reset, `mclk_o` is low; a low enable seen at a clock edge forces `mclk_o` low from that edge on.
- R2: While enabled, `mclk_o` toggles every `HALF_DIV` system clocks, so each high and each low phase lasts exactly `HALF_DIV` cycles.
- R3: While either `cfg_msync_en` or `cfg_mclk_en` is low, `msync_o` is low, whatever `sync_in` does.
- R4: With both enables high, a rising edge on `sync_in` (held at least 3 cycles) produces exactly one `msync_o` pulse. The pulse rises within `3 + 2*HALF_DIV + 1` cycles of the edge.
- R5: `msync_o` rises and falls only in the cycles where `mclk_o` rises, and stays high for exactly `4*HALF_DIV` cycles (two master clock periods).
- R6: A `sync_in` rising edge that arrives while a sync pulse is pending or in progress is ignored; no second pulse follows.
- R7: After t0 (the second `mclk_o` rise of a sync pulse, phase 0), `bit_valid_o` is high for one cycle on every `mclk_o` rise of phase 2, that is on rises 2, 6, 10, … counted from t0. In that cycle `bit_o` holds the `mdata_in` value present at that rising edge.
- R8: No `bit_valid_o` appears after reset, or after the master clock is disabled, until a new sync pulse has reached its t0.
- R9: A high `mflag_in` in any cycle sets a sticky error. `err_status_o` changes only on the edge after a `word_strobe` cycle: it then takes the sticky error OR the flag of that same cycle, and the sticky error clears.
- R10: Under reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mclk_en | input | 1 | Enables master clock generation |
| cfg_msync_en | input | 1 | Enables sync pulse generation |
| sync_in | input | 1 | External synchronisation request, asynchronous |
| mdata_in | input | 1 | One-bit modulator data stream |
| mflag_in | input | 1 | Modulator over-range flag |
| word_strobe | input | 1 | Output word boundary strobe |
| mclk_o | output | 1 | Modulator master clock |
| msync_o | output | 1 | Modulator sync pulse |
| bit_o | output | 1 | Sampled data bit |
| bit_valid_o | output | 1 | One-cycle strobe qualifying `bit_o` |
| err_status_o | output | 1 | Error status of the latest output word |

## Verification
The master clock toggles, the data bit strobe and the status update each appear one system clock edge after the inputs that cause them. The bench therefore records the inputs applied before each edge and compares the outputs half a cycle after that edge. A sync request reaches `msync_o` only after three synchroniser stages and a wait for the next master clock rise. That latency is checked against a window bound rather than an exact cycle. Sample phase is tracked by counting observed `mclk_o` rises from each `msync_o` rise, so the bench predicts every bit strobe from port activity alone.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
package mcs_pkg;
    // master clock periods per data bit
    localparam int unsigned BIT_PERIOD = 4;
    localparam int unsigned PHASE_W    = $clog2(BIT_PERIOD);
    // rising edge within a bit slot where the data bit is taken
    localparam logic [PHASE_W-1:0] SAMPLE_PHASE = PHASE_W'(2);

    typedef enum logic [1:0] {
        SG_IDLE  = 2'd0,
        SG_ARMED = 2'd1,
        SG_PULSE = 2'd2
    } sg_state_e;
endpackage

// File: rtl/mcs_clkdiv.sv
`timescale 1ns/1ps
module mcs_clkdiv #(
    parameter int unsigned HALF_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mclk_o,
    output logic rise_o
);
    localparam int unsigned CNT_W = $clog2(HALF_DIV + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             level;
    } div_t;

    div_t div_d, div_q;
    logic rise_c;

    always_comb begin
        div_d  = div_q;
        rise_c = 1'b0;
        if (!en) begin
            div_d.cnt   = '0;
            div_d.level = 1'b0;
        end else if (div_q.cnt == CNT_TOP) begin
            div_d.cnt   = '0;
            div_d.level = ~div_q.level;
            rise_c      = ~div_q.level;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign mclk_o = div_q.level;
    // high in the cycle whose closing edge drives mclk_o high
    assign rise_o = rise_c;
endmodule

// File: rtl/mcs_syncgen.sv
`timescale 1ns/1ps
module mcs_syncgen
    import mcs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_en,
    input  logic msync_en,
    input  logic sync_in,
    input  logic rise,
    output logic msync_o,
    output logic t0_o,
    output logic realign_o
);
    typedef struct packed {
        logic [SYNC_STAGES:0] sh;
        sg_state_e            st;
        logic                 after_t0;
        logic                 pulse;
    } sg_t;

    sg_t  sg_d, sg_q;
    logic edge_c;
    logic t0_c;

    assign edge_c = sg_q.sh[SYNC_STAGES-1] & ~sg_q.sh[SYNC_STAGES];

    always_comb begin
        sg_d    = sg_q;
        t0_c    = 1'b0;
        sg_d.sh = {sg_q.sh[SYNC_STAGES-1:0], sync_in};
        if (!mclk_en || !msync_en) begin
            sg_d.st       = SG_IDLE;
            sg_d.pulse    = 1'b0;
            sg_d.after_t0 = 1'b0;
        end else begin
            case (sg_q.st)
                SG_IDLE: begin
                    if (edge_c) begin
                        sg_d.st = SG_ARMED;
                    end
                end
                SG_ARMED: begin
                    if (rise) begin
                        sg_d.st       = SG_PULSE;
                        sg_d.pulse    = 1'b1;
                        sg_d.after_t0 = 1'b0;
                    end
                end
                SG_PULSE: begin
                    if (rise) begin
                        if (!sg_q.after_t0) begin
                            t0_c          = 1'b1;
                            sg_d.after_t0 = 1'b1;
                        end else begin
                            sg_d.pulse    = 1'b0;
                            sg_d.after_t0 = 1'b0;
                            sg_d.st       = SG_IDLE;
                        end
                    end
                end
                default: begin
                    sg_d.st    = SG_IDLE;
                    sg_d.pulse = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sg_q    <= '0;
            sg_q.st <= SG_IDLE;
        end else begin
            sg_q <= sg_d;
        end
    end

    assign msync_o   = sg_q.pulse;
    assign t0_o      = t0_c;
    // from arming until t0 the old bit phase is no longer trusted
    assign realign_o = (sg_q.st == SG_ARMED) ||
                       ((sg_q.st == SG_PULSE) && !sg_q.after_t0);
endmodule

// File: rtl/mcs_sampler.sv
`timescale 1ns/1ps
module mcs_sampler
    import mcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_en,
    input  logic rise,
    input  logic t0,
    input  logic realign,
    input  logic mdata_in,
    input  logic mflag_in,
    input  logic word_strobe,
    output logic bit_o,
    output logic bit_valid_o,
    output logic err_status_o
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               aligned;
        logic               dbit;
        logic               valid;
        logic               err;
        logic               status;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d       = smp_q;
        smp_d.valid = 1'b0;
        if (!mclk_en) begin
            smp_d.phase   = '0;
            smp_d.aligned = 1'b0;
        end else if (t0) begin
            smp_d.phase   = '0;
            smp_d.aligned = 1'b1;
        end else if (rise && smp_q.aligned && !realign) begin
            smp_d.phase = smp_q.phase + 1'b1;
            if (smp_d.phase == SAMPLE_PHASE) begin
                smp_d.dbit  = mdata_in;
                smp_d.valid = 1'b1;
            end
        end

        if (word_strobe) begin
            smp_d.status = smp_q.err | mflag_in;
            smp_d.err    = 1'b0;
        end else begin
            smp_d.err = smp_q.err | mflag_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign bit_o        = smp_q.dbit;
    assign bit_valid_o  = smp_q.valid;
    assign err_status_o = smp_q.status;
endmodule

// File: rtl/mcs_ctrl.sv
`timescale 1ns/1ps
module mcs_ctrl #(
    parameter int unsigned HALF_DIV    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_mclk_en,
    input  logic cfg_msync_en,
    input  logic sync_in,
    input  logic mdata_in,
    input  logic mflag_in,
    input  logic word_strobe,
    output logic mclk_o,
    output logic msync_o,
    output logic bit_o,
    output logic bit_valid_o,
    output logic err_status_o
);
    logic rise_w;
    logic t0_w;
    logic realign_w;

    mcs_clkdiv #(.HALF_DIV(HALF_DIV)) clkdiv_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_mclk_en),
        .mclk_o (mclk_o),
        .rise_o (rise_w)
    );

    mcs_syncgen #(.SYNC_STAGES(SYNC_STAGES)) syncgen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mclk_en   (cfg_mclk_en),
        .msync_en  (cfg_msync_en),
        .sync_in   (sync_in),
        .rise      (rise_w),
        .msync_o   (msync_o),
        .t0_o      (t0_w),
        .realign_o (realign_w)
    );

    mcs_sampler sampler_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mclk_en      (cfg_mclk_en),
        .rise         (rise_w),
        .t0           (t0_w),
        .realign      (realign_w),
        .mdata_in     (mdata_in),
        .mflag_in     (mflag_in),
        .word_strobe  (word_strobe),
        .bit_o        (bit_o),
        .bit_valid_o  (bit_valid_o),
        .err_status_o (err_status_o)
    );
endmodule

// File: rtl/mcs_ctrl_chk.sv
`timescale 1ns/1ps
module mcs_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_mclk_en,
    input logic cfg_msync_en,
    input logic word_strobe,
    input logic mclk_o,
    input logic msync_o,
    input logic bit_valid_o,
    input logic err_status_o
);
    AST_MCLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mclk_en |=> !mclk_o); // R1

    AST_MSYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_msync_en || !cfg_mclk_en) |=> !msync_o); // R3

    AST_MSYNC_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msync_o) |-> $rose(mclk_o)); // R5

    AST_MSYNC_END_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(msync_o) && $past(cfg_mclk_en) && $past(cfg_msync_en)) |-> $rose(mclk_o)); // R5

    AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> $rose(mclk_o)); // R7

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |=> !bit_valid_o); // R7

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_strobe |=> $stable(err_status_o)); // R9
endmodule

bind mcs_ctrl mcs_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_mclk_en  (cfg_mclk_en),
    .cfg_msync_en (cfg_msync_en),
    .word_strobe  (word_strobe),
    .mclk_o       (mclk_o),
    .msync_o      (msync_o),
    .bit_valid_o  (bit_valid_o),
    .err_status_o (err_status_o)
);

// File: tb/mcs_ctrl_tb_top.sv
`timescale 1ns/1ps
module mcs_ctrl_tb_top;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_mclk_en = 1'b0, cfg_msync_en = 1'b0;
    logic sync_in = 1'b0, mdata_in = 1'b0, mflag_in = 1'b0, word_strobe = 1'b0;
    logic mclk_o, msync_o, bit_o, bit_valid_o, err_status_o;

    int n_chk = 0, n_fail = 0, n_ms = 0, n_valid = 0;
    bit mon_en = 1'b0, done = 1'b0;

    always #4 clk = ~clk;

    mcs_ctrl #(.HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mclk_en(cfg_mclk_en), .cfg_msync_en(cfg_msync_en),
        .sync_in(sync_in), .mdata_in(mdata_in), .mflag_in(mflag_in), .word_strobe(word_strobe),
        .mclk_o(mclk_o), .msync_o(msync_o), .bit_o(bit_o), .bit_valid_o(bit_valid_o),
        .err_status_o(err_status_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_valid(input bit rose, input bit al, input int ridx);
        return rose && al && (ridx >= 3) && (((ridx - 3) % 4) == 0);
    endfunction

    // port-level reference, evaluated at each falling edge
    bit p_mclk = 0, p_ms = 0, seen = 0, al = 0, pend = 0;
    bit l_men = 0, l_sen = 0, l_data = 0, l_flag = 0, l_strb = 0;
    bit e_err = 0, e_stat = 0;
    int run = 0, mrun = 0, ridx = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            bit rose, ms_rose, ms_fell, ev;
            rose    = mclk_o && !p_mclk;
            ms_rose = msync_o && !p_ms;
            ms_fell = !msync_o && p_ms;
            if (!l_men) begin
                chk(mclk_o == 1'b0, "R1", mclk_o, 0);
                seen = 0; run = 0;
            end else if (mclk_o == p_mclk) begin
                run++;
            end else begin
                if (seen) chk(run == HALF, "R2", run, HALF);
                seen = 1; run = 1;
            end
            if (!l_men || !l_sen) chk(msync_o == 1'b0, "R3", msync_o, 0);
            if (ms_rose) begin
                chk(rose, "R5", rose, 1);
                mrun = 1; n_ms++;
            end else if (msync_o) begin
                mrun++;
            end
            if (ms_fell && l_men && l_sen) begin
                chk(mrun == 4 * HALF, "R5", mrun, 4 * HALF);
                chk(rose, "R5", rose, 1);
            end
            if (!l_men) begin al = 0; pend = 0; ridx = 0; end
            if (ms_rose) begin
                al = 0; pend = 1; ridx = 0;
            end else if (rose && (al || pend)) begin
                ridx++;
                if (pend && ridx == 1) begin al = 1; pend = 0; end
            end
            ev = exp_valid(rose, al, ridx);
            chk(bit_valid_o == ev, al ? "R7" : "R8", bit_valid_o, ev);
            if (ev && bit_valid_o) begin
                chk(bit_o == l_data, "R7", bit_o, l_data);
                n_valid++;
            end
            if (l_strb) begin
                e_stat = e_err | l_flag; e_err = 0;
            end else begin
                e_err = e_err | l_flag;
            end
            chk(err_status_o == e_stat, "R9", err_status_o, e_stat);
            p_mclk = mclk_o; p_ms = msync_o;
        end
        l_men = cfg_mclk_en; l_sen = cfg_msync_en;
        l_data = mdata_in; l_flag = mflag_in; l_strb = word_strobe;
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sync_pulse();
        sync_in = 1'b1; cyc(4);
        sync_in = 1'b0; cyc(4);
    endtask

    initial begin
        int base, wait_n;
        void'($urandom(32'h5eed_0042));
        cyc(5);
        @(negedge clk);
        chk({mclk_o, msync_o, bit_o, bit_valid_o, err_status_o} == 5'b0, "R10",
            {mclk_o, msync_o, bit_o, bit_valid_o, err_status_o}, 0);
        cyc(1);
        rst_n = 1'b1;
        mon_en = 1'b1;
        // everything disabled
        cyc(30); sync_pulse(); cyc(30);
        chk(n_ms == 0, "R3", n_ms, 0);
        // clock on, sync off
        cfg_mclk_en = 1'b1;
        cyc(60); sync_pulse(); cyc(60);
        chk(n_ms == 0, "R3", n_ms, 0);
        chk(n_valid == 0, "R8", n_valid, 0);
        // sync on: latency and single pulse
        cfg_msync_en = 1'b1;
        cyc(7);
        base = n_ms;
        sync_in = 1'b1;
        wait_n = 0;
        while (!msync_o && wait_n < 3 + 2 * HALF + 4) begin
            @(negedge clk); wait_n++;
        end
        chk(msync_o && wait_n <= 3 + 2 * HALF + 2, "R4", wait_n, 3 + 2 * HALF + 2);
        // edge again inside the pulse
        cyc(1); sync_in = 1'b0; cyc(4); sync_in = 1'b1; cyc(4); sync_in = 1'b0;
        while (msync_o) @(negedge clk);
        cyc(16 * HALF);
        chk(n_ms == base + 1, "R6", n_ms - base, 1);
        chk(n_valid > 0, "R7", n_valid, 1);
        // sticky error directed case
        cyc(3);
        mflag_in = 1'b1; cyc(1); mflag_in = 1'b0; cyc(10);
        @(negedge clk);
        chk(err_status_o == 1'b0, "R9", err_status_o, 0);
        cyc(1); word_strobe = 1'b1; cyc(1); word_strobe = 1'b0;
        @(negedge clk);
        chk(err_status_o == 1'b1, "R9", err_status_o, 1);
        cyc(1); word_strobe = 1'b1; cyc(1); word_strobe = 1'b0;
        @(negedge clk);
        chk(err_status_o == 1'b0, "R9", err_status_o, 0);
        // flag and strobe in the same cycle
        cyc(1); mflag_in = 1'b1; word_strobe = 1'b1; cyc(1); mflag_in = 1'b0; word_strobe = 1'b0;
        @(negedge clk);
        chk(err_status_o == 1'b1, "R9", err_status_o, 1);
        // random traffic
        begin
            int sync_left = 0;
            for (int i = 0; i < 20000; i++) begin
                cyc(1);
                mdata_in    = 1'($urandom % 2);
                mflag_in    = ($urandom % 50) == 0;
                word_strobe = ($urandom % 40) == 0;
                if (sync_left > 0) begin
                    sync_left--;
                    sync_in = (sync_left >= 4);
                end else if (($urandom % 1500) == 0) begin
                    sync_left = 8;
                    sync_in = 1'b1;
                end
            end
        end
        sync_in = 1'b0; mflag_in = 1'b0; word_strobe = 1'b0;
        cyc(20);
        // clock off, then on again without sync
        base = n_valid;
        cfg_mclk_en = 1'b0; cyc(40);
        cfg_mclk_en = 1'b1; cyc(300);
        chk(n_valid == base, "R8", n_valid - base, 0);
        sync_pulse(); cyc(40 * HALF);
        chk(n_valid > base, "R7", n_valid - base, 1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule